// File: doc/BRIEF.md
# Packed-Pixel Component-Wise Comparator

This block decides, for two 16-bit packed colour words, whether every colour component of the first word is at least as large as the matching component of the second. The word holds three unsigned fields: blue in the low bits, green in the middle and red at the top. The answer comes from a single subtraction across the whole word. The block then reads the borrow that leaves each field and does not compare the fields one at a time. A build-time parameter picks one of three equivalent ways to recover those borrows:

- borrow bits taken at the top bit of each field;
- carry-difference bits taken just above each field, from a subtraction one bit wider than the word;
- operands spread out with a zero guard bit above each field, then guard bits tested after the subtraction.

The operands arrive with a single-cycle input strobe, and there is no handshake. A small two-state output sequencer registers the answer. It raises a result strobe on the cycle after each input strobe. The states are `ST_IDLE` (no fresh result) and `ST_EMIT` (a fresh result is on the output). From either state, a strobe moves the sequencer to `ST_EMIT`. From either state, no strobe moves it to `ST_IDLE`.

Top module: `pxcmp_top`

## Requirements
- R1: Blue is bits 4:0, green is bits 10:5 and red is bits 15:11, all unsigned. `ge_out` is 1 exactly when red, green and blue of `x_in` are each greater than or equal to the same field of `y_in`.
- R2: After a clock edge that samples `in_valid` high, `ge_valid` is 1 and `ge_out` carries the answer for the sampled operands.
- R3: After an edge that samples `in_valid` low, `ge_valid` is 0 and `ge_out` keeps its previous value.
- R4: Equal operands (`x_in` equal to `y_in`) always give `ge_out` = 1.
- R5: `x_in`=0x0000 against `y_in`=0xFFFF gives 0. `x_in`=0xFFFF against `y_in`=0x0000 gives 1.
- R6: A borrow out of a lower field never decides a higher field. For example, `x_in`=0x0800 against `y_in`=0x001F gives 0 although `x_in` is larger as a whole word. `x_in`=0x0820 against `y_in`=0x0800 gives 1.
- R7: Each of the three values of the `VARIANT` parameter (0 borrow-at-top-bit, 1 carry-above-field, 2 guard-spread) gives the same `ge_out` for every operand pair.
- R8: While `rst_n` is low and at the first edge after its release, `ge_out` and `ge_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| x_in | input | 16 | First packed colour word |
| y_in | input | 16 | Second packed colour word |
| ge_out | output | 1 | Registered all-components-greater-or-equal answer |
| ge_valid | output | 1 | High for one cycle per answered strobe |

## Verification
The assertions assume that `in_valid`, `x_in` and `y_in` are known, valid values whenever they are sampled. They also assume that `in_valid` stays low throughout reset. The assertions place no other condition on the operands, since every bit pattern is a legal pixel. The bench changes inputs only on falling clock edges and holds the strobe low during reset. It sends the boundary sweep and the random pairs as a continuous stream of strobes, with one deliberate gap to observe the hold behaviour.

// File: rtl/pxcmp_pkg.sv
`timescale 1ns/1ps
package pxcmp_pkg;

    // Datapath chosen at build time; all three give identical answers.
    typedef enum int {
        VAR_BORROW_MSB   = 0,
        VAR_XOR_ABOVE    = 1,
        VAR_GUARD_SPREAD = 2
    } variant_e;

    // Output sequencer states.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } out_state_e;

endpackage

// File: rtl/pxcmp_borrow_msb.sv
`timescale 1ns/1ps
// Borrow out of each field, taken at the field's top bit of a word-wide difference.
module pxcmp_borrow_msb #(
    parameter int B_W = 5,
    parameter int G_W = 6,
    parameter int R_W = 5
) (
    input  logic [B_W+G_W+R_W-1:0] x,
    input  logic [B_W+G_W+R_W-1:0] y,
    output logic                   ge
);
    localparam int W = B_W + G_W + R_W;
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] TOP_MASK = (ONE << (B_W - 1))
                                      | (ONE << (B_W + G_W - 1))
                                      | (ONE << (W - 1));

    logic [W-1:0] diff;
    logic [W-1:0] bout;

    always_comb begin
        diff = x - y;
        // Borrow out of bit i: y set where x clear, or equal bits passing a borrow in.
        bout = (~x & y) | (~(x ^ y) & diff);
        ge   = ~|(bout & TOP_MASK);
    end

endmodule

// File: rtl/pxcmp_xor_above.sv
`timescale 1ns/1ps
// Borrow into the bit just above each field, recovered as x ^ y ^ diff.
module pxcmp_xor_above #(
    parameter int B_W = 5,
    parameter int G_W = 6,
    parameter int R_W = 5
) (
    input  logic [B_W+G_W+R_W-1:0] x,
    input  logic [B_W+G_W+R_W-1:0] y,
    output logic                   ge
);
    localparam int W  = B_W + G_W + R_W;
    localparam int XW = W + 1;
    localparam logic [XW-1:0] ONE = {{(XW-1){1'b0}}, 1'b1};
    localparam logic [XW-1:0] ABOVE_MASK = (ONE << B_W)
                                         | (ONE << (B_W + G_W))
                                         | (ONE << W);

    logic [XW-1:0] xe;
    logic [XW-1:0] ye;
    logic [XW-1:0] diff;
    logic [XW-1:0] bin;

    always_comb begin
        xe   = {1'b0, x};
        ye   = {1'b0, y};
        diff = xe - ye;
        bin  = xe ^ ye ^ diff;
        ge   = ~|(bin & ABOVE_MASK);
    end

endmodule

// File: rtl/pxcmp_guard_spread.sv
`timescale 1ns/1ps
// Operands spread with a zero guard bit above each field; a set guard after
// the subtraction marks a borrow out of the field below it.
module pxcmp_guard_spread #(
    parameter int B_W = 5,
    parameter int G_W = 6,
    parameter int R_W = 5
) (
    input  logic [B_W+G_W+R_W-1:0] x,
    input  logic [B_W+G_W+R_W-1:0] y,
    output logic                   ge
);
    localparam int W    = B_W + G_W + R_W;
    localparam int SW   = W + 3;
    localparam int G0   = B_W;
    localparam int G1   = B_W + G_W + 1;
    localparam int G2   = W + 2;
    localparam logic [SW-1:0] ONE = {{(SW-1){1'b0}}, 1'b1};
    localparam logic [SW-1:0] GUARD_MASK = (ONE << G0) | (ONE << G1) | (ONE << G2);

    logic [SW-1:0] xs;
    logic [SW-1:0] ys;
    logic [SW-1:0] diff;

    always_comb begin
        xs   = {1'b0, x[W-1:B_W+G_W], 1'b0, x[B_W+G_W-1:B_W], 1'b0, x[B_W-1:0]};
        ys   = {1'b0, y[W-1:B_W+G_W], 1'b0, y[B_W+G_W-1:B_W], 1'b0, y[B_W-1:0]};
        diff = xs - ys;
        ge   = ~|(diff & GUARD_MASK);
    end

endmodule

// File: rtl/pxcmp_top.sv
`timescale 1ns/1ps
module pxcmp_top #(
    parameter int B_W = 5,
    parameter int G_W = 6,
    parameter int R_W = 5,
    parameter pxcmp_pkg::variant_e VARIANT = pxcmp_pkg::VAR_BORROW_MSB
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [15:0] x_in,
    input  logic [15:0] y_in,
    output logic        ge_out,
    output logic        ge_valid
);
    import pxcmp_pkg::*;

    localparam int W = B_W + G_W + R_W;

    logic       ge_comb;
    out_state_e state_q;
    out_state_e state_d;

    // Datapath selection.
    generate
        if (VARIANT == VAR_XOR_ABOVE) begin : g_xor
            pxcmp_xor_above #(.B_W(B_W), .G_W(G_W), .R_W(R_W)) u_dp (
                .x(x_in[W-1:0]), .y(y_in[W-1:0]), .ge(ge_comb));
        end else if (VARIANT == VAR_GUARD_SPREAD) begin : g_guard
            pxcmp_guard_spread #(.B_W(B_W), .G_W(G_W), .R_W(R_W)) u_dp (
                .x(x_in[W-1:0]), .y(y_in[W-1:0]), .ge(ge_comb));
        end else begin : g_msb
            pxcmp_borrow_msb #(.B_W(B_W), .G_W(G_W), .R_W(R_W)) u_dp (
                .x(x_in[W-1:0]), .y(y_in[W-1:0]), .ge(ge_comb));
        end
    endgenerate

    // Next-state decision.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register: load on strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        ge_out <= 1'b0;
        else if (in_valid) ge_out <= ge_comb;
    end

    assign ge_valid = (state_q == ST_EMIT);

    // Field-by-field reference for the assertions only.
    logic ref_ge;
    always_comb begin
        ref_ge = (x_in[W-1:B_W+G_W]     >= y_in[W-1:B_W+G_W])
              && (x_in[B_W+G_W-1:B_W]   >= y_in[B_W+G_W-1:B_W])
              && (x_in[B_W-1:0]         >= y_in[B_W-1:0]);
    end

    assert_field_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (ge_out == $past(ref_ge)));
    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ge_valid);
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!ge_valid && $stable(ge_out)));
    assert_equal_true_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && x_in == y_in) |=> ge_out);
    assert_zero_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && x_in == 16'h0000 && y_in != 16'h0000) |=> !ge_out);
    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (!ge_out && !ge_valid));

endmodule

// File: tb/pxcmp_top_test.sv
`timescale 1ns/1ps
module pxcmp_top_test;
    import pxcmp_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] x_in = 16'h0;
    logic [15:0] y_in = 16'h0;
    logic        ge0, ge1, ge2, gv0, gv1, gv2;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    pxcmp_top #(.VARIANT(VAR_BORROW_MSB)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in), .y_in(y_in),
        .ge_out(ge0), .ge_valid(gv0));
    pxcmp_top #(.VARIANT(VAR_XOR_ABOVE)) uut_xor (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in), .y_in(y_in),
        .ge_out(ge1), .ge_valid(gv1));
    pxcmp_top #(.VARIANT(VAR_GUARD_SPREAD)) uut_guard (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in), .y_in(y_in),
        .ge_out(ge2), .ge_valid(gv2));

    function automatic logic model_ge(input logic [15:0] a, input logic [15:0] b);
        int ar = a / 2048;
        int br = b / 2048;
        int ag = (a / 32) % 64;
        int bg = (b / 32) % 64;
        int ab = a % 32;
        int bb = b % 32;
        return (ar >= br) && (ag >= bg) && (ab >= bb);
    endfunction

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b (x=%h y=%h)", tag, act, exp, x_in, y_in);
        end
    endtask

    // Called at a falling edge: drive a strobed pair, check at the next falling edge.
    task automatic apply(input logic [15:0] a, input logic [15:0] b, input string tag);
        logic e;
        x_in = a; y_in = b; in_valid = 1'b1;
        e = model_ge(a, b);
        @(negedge clk);
        check_bit({tag, " R1 R2 variant0"}, ge0, e);
        check_bit({tag, " R7 variant1"}, ge1, e);
        check_bit({tag, " R7 variant2"}, ge2, e);
        check_bit({tag, " R2 valid"}, gv0 & gv1 & gv2, 1'b1);
    endtask

    task automatic expect_fixed(input logic [15:0] a, input logic [15:0] b,
                                input logic e, input string tag);
        x_in = a; y_in = b; in_valid = 1'b1;
        @(negedge clk);
        check_bit({tag, " v0"}, ge0, e);
        check_bit({tag, " v1"}, ge1, e);
        check_bit({tag, " v2"}, ge2, e);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        int vals_b[4];
        int vals_g[4];
        int prev;
        vals_b = '{0, 1, 30, 31};
        vals_g = '{0, 1, 62, 63};

        // R8: reset state
        repeat (3) @(negedge clk);
        check_bit("R8 reset ge_out", ge0 | ge1 | ge2, 1'b0);
        check_bit("R8 reset ge_valid", gv0 | gv1 | gv2, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R8 after release ge_out", ge0 | ge1 | ge2, 1'b0);
        check_bit("R8 after release ge_valid", gv0 | gv1 | gv2, 1'b0);

        // R5 corners
        expect_fixed(16'h0000, 16'hFFFF, 1'b0, "R5 zero vs ones");
        expect_fixed(16'hFFFF, 16'h0000, 1'b1, "R5 ones vs zero");
        // R4 equal operands
        expect_fixed(16'h0000, 16'h0000, 1'b1, "R4 equal zero");
        expect_fixed(16'hFFFF, 16'hFFFF, 1'b1, "R4 equal ones");
        expect_fixed(16'h5A3C, 16'h5A3C, 1'b1, "R4 equal mixed");
        // R6 borrow isolation
        expect_fixed(16'h0800, 16'h001F, 1'b0, "R6 red up blue down");
        expect_fixed(16'h0820, 16'h0800, 1'b1, "R6 green up red equal");
        expect_fixed(16'h0020, 16'h0001, 1'b0, "R6 green up blue down");
        expect_fixed(16'h8000, 16'h07E0, 1'b0, "R6 red up green down");

        // R3: gap with no strobe, output holds and valid drops
        prev = ge0;
        in_valid = 1'b0;
        x_in = 16'hFFFF; y_in = 16'h0000;
        @(negedge clk);
        check_bit("R3 valid low", gv0 | gv1 | gv2, 1'b0);
        check_bit("R3 hold v0", ge0, prev[0]);
        check_bit("R3 hold v1", ge1, prev[0]);
        check_bit("R3 hold v2", ge2, prev[0]);

        // R1/R7: boundary sweep over every field
        foreach (vals_b[rx]) foreach (vals_b[ry])
            foreach (vals_g[gx]) foreach (vals_g[gy])
                foreach (vals_b[bx]) foreach (vals_b[by])
                    apply({vals_b[rx][4:0], vals_g[gx][5:0], vals_b[bx][4:0]},
                          {vals_b[ry][4:0], vals_g[gy][5:0], vals_b[by][4:0]},
                          "sweep");

        // R1/R7: random pairs, half with a shared upper part
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a;
            logic [15:0] b;
            a = 16'($urandom);
            b = 16'($urandom);
            if (i % 2 == 1) b[15:11] = a[15:11];
            if (i % 4 == 3) b[10:5] = a[10:5];
            apply(a, b, "random");
        end

        in_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule